// File: doc/BRIEF.md
# Single-Master Peripheral Bus Fabric

This block joins one processor-style master to twelve memory-mapped peripherals. It uses 16-bit addresses and separate 16-bit data paths in each direction, with no tristate nets. The master sets up an address, a write flag and write data, then raises a request. The fabric captures the whole request in registers on the next clock edge. It then presents the captured address, write data and write flag to every peripheral at once. A single select line, decoded from the upper address byte, tells the addressed peripheral that the access belongs to it.

The selected peripheral answers with read data and an acknowledge. It may take as many cycles as it needs, which stalls the master. The fabric picks that peripheral's response through an AND-OR multiplexer and registers it, then raises its own acknowledge to the master. Both handshakes are four-phase. The fabric releases the master only after the master has dropped its request and the peripheral has dropped its acknowledge.

Registers sit on the select path and on the response path. As a result, no combinational path runs from a master input to a master output. An access to a page that no peripheral owns still completes: the fabric answers it after a fixed delay with zero data, so the master cannot hang.

Top module: `pbus_fabric`

## Requirements
- R1: After reset, `m_ack`, `s_req`, every bit of `s_sel` and all of `m_rdata` are 0.
- R2: An address whose upper byte equals `BASE_PAGE + i` (default `BASE_PAGE` = 8'h10, i from 0 to 11) asserts only `s_sel[i]`, starting in the cycle after the request is captured.
- R3: In the cycle after a rising `m_req` is captured in the idle state, `s_req` is 1 and `s_addr`, `s_wdata` and `s_we` equal the values the master presented at capture. These values are shared by all peripherals.
- R4: `m_rdata` carries the selected peripheral's `s_rdata` word. `m_ack` rises one clock edge after the selected `s_ack` is seen high, never in the same cycle.
- R5: `s_req` falls on the edge where the peripheral acknowledge is captured. `m_ack` then stays high until `m_req` is low and the selected `s_ack` is low, and `s_sel` returns to 0 on that same edge.
- R6: For an address whose upper byte matches no peripheral, no select and no `s_req` are raised. `m_ack` rises `TMO_CYC` (default 16) edges after the capture edge, with `m_rdata` = 0.
- R7: An `s_ack` from a peripheral that is not selected has no effect on `m_ack` or `m_rdata`.
- R8: The captured address, write data and select stay unchanged while the access is in flight, even if `m_addr` or `m_wdata` change after capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master write flag (1 = write) |
| m_addr | input | 16 | Master address |
| m_wdata | input | 16 | Master write data |
| m_rdata | output | 16 | Response data to master |
| m_ack | output | 1 | Acknowledge to master |
| s_req | output | 1 | Request shared by all peripherals |
| s_we | output | 1 | Captured write flag, shared |
| s_addr | output | 16 | Captured address, shared |
| s_wdata | output | 16 | Captured write data, shared |
| s_sel | output | 12 | One select line per peripheral |
| s_rdata | input | 192 | Peripheral read data; peripheral i uses bits [16*i+15:16*i] |
| s_ack | input | 12 | Peripheral acknowledges, one per peripheral |

## Verification
The bench places a stray acknowledge with a poison data word on a peripheral that is not addressed. A fabric that does not mask acknowledges with the select would finish the access early or return the poison word. It also changes `m_addr` and `m_wdata` in the middle of an access. A fabric that decodes live inputs would switch peripherals or store the wrong data, and a later read-back would expose that. The bench sends unmapped pages just below and just above the mapped range, plus a far page, and counts the exact timeout latency. An off-by-one counter, or a decoder that accepts a thirteenth page, changes that count or the returned zero data. After each access it holds the request for longer than needed and then releases it. This catches an acknowledge that drops early, or a select left asserted.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } pbus_state_e;
endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned N_SLV  = 12,
  parameter logic [PAGE_W-1:0] BASE_PAGE = 8'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SLV-1:0]  sel,
  output logic              hit
);
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1 -: PAGE_W];

  for (genvar i = 0; i < N_SLV; i++) begin : g_page
    localparam logic [PAGE_W-1:0] PG_I = BASE_PAGE + PAGE_W'(i);
    assign sel[i] = (page == PG_I);
  end

  assign hit = |sel;
endmodule

// File: rtl/pbus_resp_mux.sv
module pbus_resp_mux #(
  parameter int unsigned N_SLV  = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic [N_SLV-1:0]        sel,
  input  logic [N_SLV*DATA_W-1:0] rdata_bus,
  input  logic [N_SLV-1:0]        ack_bus,
  output logic [DATA_W-1:0]       rdata,
  output logic                    ack
);
  logic [DATA_W-1:0] term [N_SLV];

  for (genvar i = 0; i < N_SLV; i++) begin : g_term
    assign term[i] = rdata_bus[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_SLV; i++) begin
      rdata = rdata | term[i];
    end
  end

  assign ack = |(ack_bus & sel);
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_SLV   = 12,
  parameter int unsigned TMO_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [N_SLV-1:0]  dec_sel,
  input  logic              dec_hit,
  input  logic [DATA_W-1:0] mux_rdata,
  input  logic              mux_ack,
  output logic [DATA_W-1:0] m_rdata,
  output logic              m_ack,
  output logic              s_req,
  output logic              s_we,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  output logic [N_SLV-1:0]  s_sel
);
  localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

  pbus_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              unm_q, unm_d;
  logic              sreq_q, sreq_d;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [N_SLV-1:0]  sel_q, sel_d;
  logic              cap_en, rd_en;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unm_d   = unm_q;
    sreq_d  = sreq_q;
    ack_d   = ack_q;
    rd_d    = rd_q;
    sel_d   = sel_q;
    cap_en  = 1'b0;
    rd_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (m_req) begin
          cap_en  = 1'b1;
          sel_d   = dec_sel;
          unm_d   = ~dec_hit;
          sreq_d  = dec_hit;
          cnt_d   = '0;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (!unm_q) begin
          if (mux_ack) begin
            rd_en   = 1'b1;
            rd_d    = mux_rdata;
            ack_d   = 1'b1;
            sreq_d  = 1'b0;
            state_d = ST_DONE;
          end
        end else if (cnt_q == CNT_LAST) begin
          rd_en   = 1'b1;
          rd_d    = '0;
          ack_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (!m_req && !mux_ack) begin
          ack_d   = 1'b0;
          sel_d   = '0;
          unm_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      unm_q   <= 1'b0;
      sreq_q  <= 1'b0;
      ack_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      unm_q   <= unm_d;
      sreq_q  <= sreq_d;
      ack_q   <= ack_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (cap_en) begin
      we_q   <= m_we;
      addr_q <= m_addr;
      wd_q   <= m_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign m_rdata = rd_q;
  assign m_ack   = ack_q;
  assign s_req   = sreq_q;
  assign s_we    = we_q;
  assign s_addr  = addr_q;
  assign s_wdata = wd_q;
  assign s_sel   = sel_q;

  p_ack_after_slave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && !unm_q) |-> $past(mux_ack))
    else $error("m_ack rose without a prior selected acknowledge");

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> ($past(!m_req) && $past(!mux_ack)))
    else $error("m_ack dropped before both request and slave ack were low");

  p_sreq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sreq_q) |-> ack_q)
    else $error("s_req dropped without m_ack");

  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && unm_q) |-> (sel_q == '0 && !sreq_q))
    else $error("unmapped access drove a select or request");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && $past(state_q == ST_BUSY))
      |-> ($stable(addr_q) && $stable(sel_q) && $stable(wd_q)))
    else $error("captured access changed while in flight");
endmodule

// File: rtl/pbus_fabric.sv
module pbus_fabric #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned N_SLV     = 12,
  parameter int unsigned PAGE_W    = 8,
  parameter logic [PAGE_W-1:0] BASE_PAGE = 8'h10,
  parameter int unsigned TMO_CYC   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    m_req,
  input  logic                    m_we,
  input  logic [ADDR_W-1:0]       m_addr,
  input  logic [DATA_W-1:0]       m_wdata,
  output logic [DATA_W-1:0]       m_rdata,
  output logic                    m_ack,
  output logic                    s_req,
  output logic                    s_we,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [DATA_W-1:0]       s_wdata,
  output logic [N_SLV-1:0]        s_sel,
  input  logic [N_SLV*DATA_W-1:0] s_rdata,
  input  logic [N_SLV-1:0]        s_ack
);
  logic [N_SLV-1:0]  dec_sel;
  logic              dec_hit;
  logic [DATA_W-1:0] mux_rdata;
  logic              mux_ack;

  pbus_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .N_SLV(N_SLV), .BASE_PAGE(BASE_PAGE)
  ) u_decode (
    .addr(m_addr), .sel(dec_sel), .hit(dec_hit)
  );

  pbus_resp_mux #(
    .N_SLV(N_SLV), .DATA_W(DATA_W)
  ) u_mux (
    .sel(s_sel), .rdata_bus(s_rdata), .ack_bus(s_ack),
    .rdata(mux_rdata), .ack(mux_ack)
  );

  pbus_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SLV(N_SLV), .TMO_CYC(TMO_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .dec_sel(dec_sel), .dec_hit(dec_hit),
    .mux_rdata(mux_rdata), .mux_ack(mux_ack),
    .m_rdata(m_rdata), .m_ack(m_ack),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_sel(s_sel)
  );

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sel))
    else $error("more than one select asserted");

  p_req_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |-> ($countones(s_sel) == 1))
    else $error("s_req raised without exactly one select");
endmodule

// File: tb/test_pbus_fabric.sv
module test_pbus_fabric;
  localparam int N    = 12;
  localparam int DW   = 16;
  localparam int AW   = 16;
  localparam int TMO  = 16;
  localparam logic [7:0] BASE = 8'h10;

  logic clk = 1'b0;
  logic rst_n;
  logic m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic m_ack, s_req, s_we;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [N-1:0] s_sel, s_ack, sack, rogue;
  logic [N*DW-1:0] s_rdata;
  logic [DW-1:0] srd [N];
  logic [DW-1:0] smem [N];
  int scnt [N];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic ack_d = 1'b0;

  typedef struct {logic [DW-1:0] d; string tag;} exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] exp_mem [N];

  always #5 clk = ~clk;

  pbus_fabric #(.TMO_CYC(TMO), .BASE_PAGE(BASE)) i_pbus_fabric (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .s_req(s_req),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_sel(s_sel),
    .s_rdata(s_rdata), .s_ack(s_ack)
  );

  // peripheral models: latency (i%4)+1 cycles, read returns stored ^ address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        sack[i] <= 1'b0; srd[i] <= '0; smem[i] <= '0; scnt[i] <= 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (s_req && s_sel[i] && !sack[i]) begin
          if (scnt[i] == i % 4) begin
            sack[i] <= 1'b1;
            srd[i]  <= s_we ? 16'h0000 : (smem[i] ^ s_addr);
            if (s_we) smem[i] <= s_wdata;
            scnt[i] <= 0;
          end else begin
            scnt[i] <= scnt[i] + 1;
          end
        end else if (!s_req) begin
          sack[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    s_ack = sack | rogue;
    for (int i = 0; i < N; i++)
      s_rdata[i*DW +: DW] = rogue[i] ? 16'hDEAD : srd[i];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // scoreboard monitor: pop on each rising acknowledge
  always @(negedge clk) begin
    if (rst_n && m_ack && !ack_d) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected ack", {16'h0, m_rdata}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(m_rdata == e.d, e.tag, {16'h0, m_rdata}, {16'h0, e.d});
      end
    end
    ack_d = m_ack;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic txn(input bit we, input logic [15:0] addr,
                     input logic [15:0] wdata, input bit alt, input string tag);
    int idx;
    bit mapped;
    int n;
    exp_t e;
    mapped = (addr[15:8] >= BASE) && (addr[15:8] < BASE + N);
    idx = mapped ? int'(addr[15:8] - BASE) : 0;
    e.tag = tag;
    if (!mapped) e.d = '0;
    else if (we) begin e.d = '0; exp_mem[idx] = wdata; end
    else e.d = exp_mem[idx] ^ addr;
    exp_q.push_back(e);

    @(negedge clk);
    m_we = we; m_addr = addr; m_wdata = wdata; m_req = 1'b1;
    @(negedge clk);
    if (mapped) begin
      chk(s_sel == (12'(1) << idx), "R2 select", {20'h0, s_sel}, 32'(1) << idx);
      chk(s_req && s_addr == addr && s_we == we && s_wdata == wdata,
          "R3 broadcast", {s_addr, s_wdata}, {addr, wdata});
    end else begin
      chk(s_sel == '0 && !s_req, "R6 no select", {19'h0, s_req, s_sel}, 32'h0);
    end
    if (alt) begin
      m_addr = addr ^ 16'h0300;
      m_wdata = ~wdata;
      @(negedge clk);
      chk(s_addr == addr && s_wdata == wdata, "R8 latched", {s_addr, s_wdata},
          {addr, wdata});
    end
    n = 1;
    while (!m_ack && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!mapped) chk(n == TMO + 1, "R6 timeout latency", n, TMO + 1);
    chk(!s_req, "R5 s_req dropped", {31'h0, s_req}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    chk(m_ack, "R5 ack held", {31'h0, m_ack}, 32'h1);
    m_req = 1'b0;
    n = 0;
    while (m_ack && n < 6) begin
      @(negedge clk);
      n++;
    end
    chk(!m_ack && s_sel == '0, "R5 release", {19'h0, m_ack, s_sel}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; m_req = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0;
    rogue = '0;
    for (int i = 0; i < N; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!m_ack && !s_req && s_sel == '0 && m_rdata == '0, "R1 reset",
        {m_rdata, 2'b0, m_ack, s_req, s_sel}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_ack && !s_req && s_sel == '0, "R1 after release",
        {19'h0, m_ack, s_sel}, 32'h0);

    // R2 R3 R4: write then read back every peripheral
    for (int i = 0; i < N; i++)
      txn(1'b1, {BASE + 8'(i), 8'(i * 7)}, 16'hA500 + 16'(i * 17), 1'b0, "R3 write ack data");
    for (int i = N - 1; i >= 0; i--)
      txn(1'b0, {BASE + 8'(i), 8'h3C}, 16'h0, 1'b0, "R4 readback");

    // R6: unmapped pages at both edges and far away
    txn(1'b0, {BASE - 8'd1, 8'h00}, 16'h0, 1'b0, "R6 below range");
    txn(1'b0, {BASE + 8'(N), 8'hFF}, 16'h0, 1'b0, "R6 above range");
    txn(1'b1, 16'hF012, 16'h1234, 1'b0, "R6 far page write");

    // R7: stray acks from unselected peripherals
    rogue = 12'b0000_0000_0100;
    txn(1'b0, {BASE + 8'd5, 8'h11}, 16'h0, 1'b0, "R7 stray ack ignored");
    rogue = 12'b1111_1111_1111;
    txn(1'b0, {BASE + 8'd40, 8'h00}, 16'h0, 1'b0, "R7 stray ack on unmapped");
    rogue = '0;

    // R8: inputs change after capture
    txn(1'b1, {BASE + 8'd2, 8'h44}, 16'h5A5A, 1'b1, "R8 write with moving inputs");
    txn(1'b0, {BASE + 8'd2, 8'h44}, 16'h0, 1'b0, "R8 readback of latched write");
    txn(1'b0, {BASE + 8'd1, 8'h44}, 16'h0, 1'b0, "R8 neighbour untouched");
    txn(1'b0, {BASE + 8'd11, 8'h9A}, 16'h0, 1'b1, "R8 read with moving address");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all responses seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule